// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the column addresses of its burst, one per clock. The command logic presents a start address, a burst-length code and an ordering select together with a one-cycle `start` pulse. From the next cycle on, the block emits the column addresses of the burst on an address-shaped output. `col_valid` is high for each of them, and `col_last` marks the final one of a fixed-length burst.

The column index is 11 bits wide, but it sits in a 13-bit address word with a hole. Bit 10 of the word is reserved for the precharge flag and bit 12 is a row-only bit. The block gathers the index from the word and spreads each generated index back into the same positions.

Two orderings are available: linear (wrapping increment) and interleaved (XOR of the step number). There is also a full-page length that walks the whole row until it is stopped. A `stop` pulse ends any burst early. A new `start` is accepted on any clock, including mid-burst, and restarts the sequence.

Top module: `colgen_burst_addr`

## Requirements
- R1: After reset, and until the first `start`, `col_valid` and `col_last` are 0. `col_addr` is all zeros whenever `col_valid` is 0.
- R2: The start column index is `start_addr` bits 9..0 (index bits 9..0) and bit 11 (index bit 10). `start_addr` bits 10 and 12 are ignored. `col_addr` carries the index in those same positions and drives bits 10 and 12 to 0.
- R3: The `bl_code` encoding is 0 → 1 beat, 1 → 2, 2 → 4, 3 → 8, and any code with bit 2 set → full page.
- R4: When `start` is 1 at a rising edge, the following cycle shows step k=0, which is the start index, with `col_valid`=1. Each later clock advances to step k+1.
- R5: With `burst_type`=0 and length N, step k is the start index with its low log2(N) bits replaced by (start + k) mod N. The upper bits are unchanged.
- R6: With `burst_type`=1 and length N, step k is the start index with its low log2(N) bits XORed with k.
- R7: For a fixed length N, `col_last` is 1 exactly on step N-1. Without a new `start`, `col_valid` is 0 on the cycle after it.
- R8: In full page mode, step k is (start + k) mod 2048 whatever `burst_type` is. `col_last` is never 1, and the burst runs until `stop` or `start`.
- R9: `stop`=1 at an edge while `col_valid`=1 and `start`=0 makes `col_valid` 0 on the next cycle. `stop` while idle leaves the outputs idle.
- R10: `start` mid-burst restarts at the new start index with the new length and ordering. If `start` and `stop` are both 1, `start` wins. `start` on consecutive clocks yields a new step 0 each cycle.
- R11: `bl_code` and `burst_type` are sampled only with `start`. Changing them during a burst leaves that burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst from `start_addr` |
| start_addr | input | 13 | Address word holding the start column |
| bl_code | input | 3 | Burst length code (R3) |
| burst_type | input | 1 | 0 linear, 1 interleaved |
| stop | input | 1 | End the running burst |
| col_valid | output | 1 | A column address is presented |
| col_last | output | 1 | Final address of a fixed-length burst |
| col_addr | output | 13 | Column address in address-word layout |

## Verification
The assertions assume that `start` and `stop` are clean single-cycle levels sampled at the rising edge, and that `start_addr`, `bl_code` and `burst_type` matter only in a `start` cycle. The stimulus changes every input only just after the falling edge. It drives arbitrary values into the ignored address bits and changes the length and ordering inputs mid-burst, so the bench checks those assumptions instead of relying on them. The checks then sweep every fixed length under both orderings across many start columns, run a full-page burst past the row wrap, and exercise early stop, restart and back-to-back starts.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  localparam int LG_W = 2;

  typedef struct packed {
    logic            full;
    logic [LG_W-1:0] lg;
    order_e          ord;
  } burst_cfg_t;

  // Length code: bit 2 selects full page, otherwise 2**code[1:0] beats.
  function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic typ);
    burst_cfg_t c;
    c.full = code[2];
    c.lg   = code[2] ? '0 : code[LG_W-1:0];
    c.ord  = code[2] ? ORD_LINEAR : order_e'(typ);
    return c;
  endfunction

endpackage

// File: rtl/colgen_field_unpack.sv
module colgen_field_unpack #(
  parameter int ADDR_W   = 13,
  parameter int COL_W    = 11,
  parameter int SKIP_BIT = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  idx
);
  for (genvar j = 0; j < COL_W; j++) begin : g_bit
    if (j < SKIP_BIT) begin : g_low
      assign idx[j] = addr[j];
    end else begin : g_high
      assign idx[j] = addr[j+1];
    end
  end

  logic unused_addr;
  assign unused_addr = ^addr;
endmodule

// File: rtl/colgen_field_pack.sv
module colgen_field_pack #(
  parameter int ADDR_W   = 13,
  parameter int COL_W    = 11,
  parameter int SKIP_BIT = 10
) (
  input  logic [COL_W-1:0]  idx,
  input  logic              en,
  output logic [ADDR_W-1:0] addr
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < SKIP_BIT) begin : g_low
      assign addr[i] = en & idx[i];
    end else if (i == SKIP_BIT) begin : g_gap
      assign addr[i] = 1'b0;
    end else if (i - 1 < COL_W) begin : g_high
      assign addr[i] = en & idx[i-1];
    end else begin : g_pad
      assign addr[i] = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
  import colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] step,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] last_step
);
  // Bits that move within the burst; the rest stay as in base.
  function automatic logic [COL_W-1:0] span_mask(input burst_cfg_t c);
    if (c.full) return '1;
    return ~({COL_W{1'b1}} << c.lg);
  endfunction

  function automatic logic [COL_W-1:0] step_index(
    input logic [COL_W-1:0] b,
    input logic [COL_W-1:0] k,
    input burst_cfg_t       c
  );
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] low;
    m   = span_mask(c);
    low = (c.ord == ORD_XOR) ? (b ^ k) : (b + k);
    return (b & ~m) | (low & m);
  endfunction

  assign idx       = step_index(base, step, cfg);
  assign last_step = span_mask(cfg);
endmodule

// File: rtl/colgen_step_ctrl.sv
module colgen_step_ctrl
  import colgen_pkg::*;
#(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  burst_cfg_t       start_cfg,
  input  logic             stop,
  input  logic [COL_W-1:0] last_step,
  output logic             active,
  output logic [COL_W-1:0] step,
  output logic [COL_W-1:0] base,
  output burst_cfg_t       cfg,
  output logic             at_end,
  output logic             ev_stop,
  output logic             ev_end
);
  assign at_end  = active & ~cfg.full & (step == last_step);
  assign ev_stop = active & stop & ~start;
  assign ev_end  = at_end & ~start & ~stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      base   <= '0;
      cfg    <= '0;
    end else if (start) begin
      active <= 1'b1;
      step   <= '0;
      base   <= start_col;
      cfg    <= start_cfg;
    end else if (active) begin
      if (stop || at_end) active <= 1'b0;
      else                step   <= step + 1'b1;
    end
  end
endmodule

// File: rtl/colgen_burst_addr.sv
module colgen_burst_addr
  import colgen_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int COL_W    = 11,
  parameter int SKIP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        bl_code,
  input  logic              burst_type,
  input  logic              stop,
  output logic              col_valid,
  output logic              col_last,
  output logic [ADDR_W-1:0] col_addr
);
  logic [COL_W-1:0] start_col;
  logic [COL_W-1:0] cur_base;
  logic [COL_W-1:0] cur_step;
  logic [COL_W-1:0] cur_idx;
  logic [COL_W-1:0] last_step;
  burst_cfg_t       start_cfg;
  burst_cfg_t       cur_cfg;
  logic             active;
  logic             at_end;
  logic             ev_stop;
  logic             ev_end;

  assign start_cfg = decode_cfg(bl_code, burst_type);

  colgen_field_unpack #(.ADDR_W(ADDR_W), .COL_W(COL_W), .SKIP_BIT(SKIP_BIT)) u_unpack (
    .addr (start_addr),
    .idx  (start_col)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_calc (
    .base      (cur_base),
    .step      (cur_step),
    .cfg       (cur_cfg),
    .idx       (cur_idx),
    .last_step (last_step)
  );

  colgen_step_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .start_cfg (start_cfg),
    .stop      (stop),
    .last_step (last_step),
    .active    (active),
    .step      (cur_step),
    .base      (cur_base),
    .cfg       (cur_cfg),
    .at_end    (at_end),
    .ev_stop   (ev_stop),
    .ev_end    (ev_end)
  );

  colgen_field_pack #(.ADDR_W(ADDR_W), .COL_W(COL_W), .SKIP_BIT(SKIP_BIT)) u_pack (
    .idx  (cur_idx),
    .en   (active),
    .addr (col_addr)
  );

  assign col_valid = active;
  assign col_last  = at_end;
endmodule

// File: rtl/colgen_burst_addr_chk.sv
module colgen_burst_addr_chk #(
  parameter int ADDR_W   = 13,
  parameter int SKIP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              col_valid,
  input logic              col_last,
  input logic [ADDR_W-1:0] col_addr,
  input logic              ev_stop,
  input logic              ev_end
);
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_addr == '0 && !col_last));  // R1

  AST_GAP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !col_addr[SKIP_BIT]);  // R2

  AST_START_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid);  // R4

  AST_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !stop && !start) |=> (col_valid && col_addr != $past(col_addr)));  // R4

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> !col_valid);  // R7

  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !col_valid);  // R9

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && !start) |=> !col_valid);  // R9
endmodule

bind colgen_burst_addr colgen_burst_addr_chk #(.ADDR_W(ADDR_W), .SKIP_BIT(SKIP_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .col_valid (col_valid),
  .col_last  (col_last),
  .col_addr  (col_addr),
  .ev_stop   (ev_stop),
  .ev_end    (ev_end)
);

// File: tb/colgen_burst_addr_tb.sv
module colgen_burst_addr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] start_addr = '0;
  logic [2:0]  bl_code = '0;
  logic        burst_type = 1'b0;
  logic        stop = 1'b0;
  logic        col_valid;
  logic        col_last;
  logic [12:0] col_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  colgen_burst_addr u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .bl_code(bl_code), .burst_type(burst_type), .stop(stop),
    .col_valid(col_valid), .col_last(col_last), .col_addr(col_addr)
  );

  // Index bit 10 lives at word bit 11; word bits 10 and 12 stay clear.
  function automatic logic [12:0] put_col(input int idx);
    return 13'((idx % 1024) + ((idx / 1024) % 2) * 2048);
  endfunction

  function automatic int get_col(input logic [12:0] a);
    return int'(a[9:0]) + (a[11] ? 1024 : 0);
  endfunction

  function automatic int want_col(input int s, input int k, input int code, input int ilv);
    int n;
    int off;
    if (code >= 4) return (s + k) % 2048;
    n   = 1 << code;
    off = s % n;
    if (ilv != 0) return (s - off) + (off ^ k);
    return (s - off) + ((off + k) % n);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic see_idle(input string req);
    check(col_valid == 1'b0, req, col_valid, 0);
    check(col_last == 1'b0, req, col_last, 0);
    check(col_addr == 13'h0, req, col_addr, 0);
  endtask

  task automatic see_step(input int idx, input bit last, input string req);
    check(col_valid == 1'b1, req, col_valid, 1);
    check(col_addr == put_col(idx), req, col_addr, put_col(idx));
    check(col_last == last, req, col_last, last);
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic launch(input logic [12:0] a, input int code, input int ilv);
    start = 1'b1; start_addr = a; bl_code = 3'(code); burst_type = ilv[0];
    @(negedge clk);
    start = 1'b0; start_addr = 13'h1fff;
    bl_code = 3'(code ^ 5); burst_type = ~burst_type;  // R11 scramble
  endtask

  task automatic run_fixed(input logic [12:0] a, input int code, input int ilv);
    int s = get_col(a);
    int n = 1 << code;
    launch(a, code, ilv);
    for (int k = 0; k < n; k++) begin
      see_step(want_col(s, k, code, ilv), k == n - 1, ilv != 0 ? "R6" : "R5");
      @(negedge clk);
    end
    see_idle("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int starts[20] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,2047,1023,1030,517};
    int s;
    repeat (3) @(negedge clk);
    see_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    see_idle("R1");

    // R9: stop while idle
    stop = 1'b1;
    repeat (3) begin @(negedge clk); see_idle("R9"); end
    stop = 1'b0;

    // R3 R5 R6 R7 R2 R11: sweep fixed lengths, both orders, junk in bits 10/12
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int i = 0; i < 20; i++) begin
          logic [12:0] a = put_col(starts[i]);
          if (i % 2 == 1) a[10] = 1'b1;
          if (i % 3 == 0) a[12] = 1'b1;
          run_fixed(a, code, ilv);
        end

    // R8: full page past the row wrap, interleave select ignored, every code 4..7
    for (int code = 4; code < 8; code++) begin
      s = 2040 - code;
      launch(put_col(s) | 13'h0400, code, code % 2);
      for (int k = 0; k < 30; k++) begin
        see_step((s + k) % 2048, 1'b0, "R8");
        if (k == 29) stop = 1'b1;
        @(negedge clk);
      end
      stop = 1'b0;
      see_idle("R9");
    end
    s = 5;
    launch(put_col(s), 7, 0);
    for (int k = 0; k < 2100; k++) begin
      see_step((s + k) % 2048, 1'b0, "R8");
      if (k == 2099) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    see_idle("R9");

    // R9: early stop in an 8 beat burst
    s = 300;
    launch(put_col(s), 3, 1);
    for (int k = 0; k < 3; k++) begin
      see_step(want_col(s, k, 3, 1), 1'b0, "R9");
      if (k == 2) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    see_idle("R9");
    @(negedge clk);
    see_idle("R9");

    // R10: restart mid-burst with stop also high
    s = 77;
    launch(put_col(s), 3, 0);
    for (int k = 0; k < 4; k++) begin
      see_step(want_col(s, k, 3, 0), 1'b0, "R10");
      if (k < 3) @(negedge clk);
    end
    stop = 1'b1;
    launch(put_col(1201), 1, 1);
    stop = 1'b0;
    see_step(want_col(1201, 0, 1, 1), 1'b0, "R10");
    @(negedge clk);
    see_step(want_col(1201, 1, 1, 1), 1'b1, "R10");
    @(negedge clk);
    see_idle("R10");

    // R10: start on consecutive clocks
    for (int i = 0; i < 5; i++) begin
      start = 1'b1; start_addr = put_col(600 + 9 * i); bl_code = 3'd3; burst_type = 1'b0;
      @(negedge clk);
      see_step(600 + 9 * i, 1'b0, "R10");
    end
    start = 1'b0;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      see_step(want_col(636, k, 3, 0), k == 7, "R10");
    end
    @(negedge clk);
    see_idle("R7");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule